// File: doc/BRIEF.md
# Gamma Lookup Table Write Front End

This block sits behind a simple register bus and turns register writes into write strobes for a display gamma lookup table. The table stores one 10-bit value for each of red, green and blue at every slot. It can be used in two layouts: a 256-slot direct table, or a 128-slot piecewise-linear table. Software writes one channel at a time through a sequential port, with the slot pointer stepping forward on its own after each complete colour. In the 256-slot layout, software can also write all three channels of a slot at once through a packed 30-bit port.

The block holds the layout select, a 3-bit channel write mask, an 8-bit slot pointer and a channel counter. Every step of the slot pointer caused by a write goes through the same path as a bus write to the pointer register, so a step always clears the channel counter. Table writes come out as registered per-channel strobes with a shared address and packed data. The pointer and counter are brought out so that their state can be seen.

Top module: `gamma_lut_wport`

## Requirements
- R1: After reset the pointer is 0, the channel counter is 0, the 256-slot layout is selected, all three mask bits are set, and no table strobe is active.
- R2: The bus selects registers with `bus_sel`: 0 = layout, 1 = pointer, 2 = mask, 3 = sequential channel, 4 = piecewise channel, 5 = packed colour. Codes 6 and 7 are ignored. In a layout write, bit 0 picks the layout: 0 selects the 256-slot table and 1 selects the piecewise table. A layout write leaves the pointer and the counter unchanged.
- R3: In the 256-slot layout, successive sequential-channel writes go to red, then green, then blue. The data for each write is bus bits 9:0. The strobe, the address (the pointer) and the data appear in the cycle after the bus write, together with the updated pointer and counter.
- R4: The channel counter counts 0, 1, 2. On the third channel write it returns to 0 and the pointer advances by one. In the 256-slot layout the pointer wraps from 255 to 0.
- R5: Mask bit 0 enables blue, bit 1 enables green and bit 2 enables red. A channel write whose mask bit is clear produces no strobe, but it still advances the counter and the pointer as usual. A mask write leaves the counter unchanged.
- R6: In the piecewise layout, the table address is pointer bits 6:0 with address bit 7 at 0. On the step after the third channel, pointer bits 6:0 wrap within 7 bits and pointer bit 7 is kept.
- R7: A packed-colour write carries blue in bits 9:0, green in bits 19:10 and red in bits 29:20. It strobes each channel whose mask bit is set, all at the current pointer. It then advances the pointer and clears the counter, even if the counter was not 0.
- R8: A pointer write loads bus bits 7:0 into the pointer and clears the channel counter.
- R9: A sequential-channel or packed-colour write in the piecewise layout, a piecewise-channel write in the 256-slot layout, and a write with an unused select code produce no strobe and leave the pointer and the counter unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_wr | input | 1 | One-cycle register write strobe |
| bus_sel | input | 3 | Register select code |
| bus_wdata | input | 32 | Register write data |
| tbl_we | output | 3 | Table write strobes: bit 0 blue, bit 1 green, bit 2 red |
| tbl_addr | output | 8 | Table slot address |
| tbl_data | output | 30 | Table data: blue 9:0, green 19:10, red 29:20 |
| tbl_pwl | output | 1 | Set when the current table write targets the piecewise table |
| cur_index | output | 8 | Current slot pointer |
| cur_comp | output | 2 | Current channel counter (0 red, 1 green, 2 blue) |
| cur_mode_pwl | output | 1 | Current layout select |

## Verification
The bound checker watches these on every cycle:
- The channel counter never reaches 3.
- A strobe appears only after an accepted write.
- A sequential or piecewise write raises at most one strobe.
- A pointer write loads the pointer and clears the counter.
- A packed write advances the pointer and clears the counter.
- A piecewise write keeps pointer bit 7.
- Writes in the wrong layout change nothing.

Only the bench scenarios show the rest:
- Red, green and blue arrive in that order.
- Mask bits map to the right channels.
- Packed fields land in the right channels.
- The pointer wraps from 255 to 0 in the 256-slot layout, and within 7 bits in the piecewise layout.
- A packed write interrupts a half-written colour.
- The mask returns to all-enabled after a reset in mid-run.

// File: rtl/glw_pkg.sv
// Package: shared types for the gamma table write front end.
// Holds the register select codes and the per-write accept flags
// that pass from the decoder to the state and strobe logic.
package glw_pkg;

    localparam int unsigned SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_MODE  = 3'd0,
        SEL_INDEX = 3'd1,
        SEL_MASK  = 3'd2,
        SEL_SEQ   = 3'd3,
        SEL_PWL   = 3'd4,
        SEL_COL30 = 3'd5
    } reg_sel_e;

    // One flag per accepted register action in the current cycle
    typedef struct packed {
        logic mode;
        logic index;
        logic mask;
        logic seq;
        logic pwl;
        logic col;
    } acc_t;

endpackage

// File: rtl/glw_decode.sv
// Module: glw_decode
// Turns a bus write into accept flags. A channel write is accepted
// only when the current layout matches it; otherwise it is dropped.
// Assumes bus_wr lasts one cycle for each write.
module glw_decode
    import glw_pkg::*;
(
    input  logic             bus_wr,
    input  logic [SEL_W-1:0] bus_sel,
    input  logic             mode_pwl,
    output acc_t             acc
);

    // Purpose: decode the select code and gate it with the layout
    always_comb begin
        acc = '0;
        if (bus_wr) begin
            case (reg_sel_e'(bus_sel))
                SEL_MODE:  acc.mode  = 1'b1;
                SEL_INDEX: acc.index = 1'b1;
                SEL_MASK:  acc.mask  = 1'b1;
                SEL_SEQ:   acc.seq   = !mode_pwl;
                SEL_PWL:   acc.pwl   = mode_pwl;
                SEL_COL30: acc.col   = !mode_pwl;
                default:   acc       = '0;
            endcase
        end
    end

endmodule

// File: rtl/glw_index_ctrl.sv
// Module: glw_index_ctrl
// Holds the layout select, the channel mask, the slot pointer and the
// channel counter. Every pointer step is sent through the same load
// path as a bus write to the pointer, so a step always clears the
// counter. Assumes PWL_W < IDX_W.
module glw_index_ctrl
    import glw_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned PWL_W  = 7,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NCH    = 3,
    parameter int unsigned CNT_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  acc_t              acc,
    input  logic [DATA_W-1:0] wdata,
    output logic              mode_pwl,
    output logic [NCH-1:0]    mask,
    output logic [IDX_W-1:0]  idx,
    output logic [CNT_W-1:0]  comp
);

    localparam logic [CNT_W-1:0] COMP_LAST = CNT_W'(NCH - 1);

    logic             chan_wr;
    logic             step;
    logic [IDX_W-1:0] idx_inc;
    logic             idx_load;
    logic [IDX_W-1:0] idx_load_val;
    logic [CNT_W-1:0] comp_next;

    // Purpose: work out the stepped pointer for the active layout
    always_comb begin
        if (acc.pwl) begin
            idx_inc = {idx[IDX_W-1:PWL_W], idx[PWL_W-1:0] + PWL_W'(1)};
        end else begin
            idx_inc = idx + IDX_W'(1);
        end
    end

    // Purpose: merge bus pointer writes and steps into one load path
    always_comb begin
        chan_wr      = acc.seq | acc.pwl;
        step         = (chan_wr && (comp == COMP_LAST)) || acc.col;
        idx_load     = acc.index | step;
        idx_load_val = acc.index ? wdata[IDX_W-1:0] : idx_inc;
        if (idx_load) begin
            comp_next = '0;
        end else if (chan_wr) begin
            comp_next = comp + CNT_W'(1);
        end else begin
            comp_next = comp;
        end
    end

    // Purpose: hold the layout select and the channel mask
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_pwl <= 1'b0;
            mask     <= '1;
        end else begin
            if (acc.mode) begin
                mode_pwl <= wdata[0];
            end
            if (acc.mask) begin
                mask <= wdata[NCH-1:0];
            end
        end
    end

    // Purpose: hold the slot pointer and the channel counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idx  <= '0;
            comp <= '0;
        end else begin
            if (idx_load) begin
                idx <= idx_load_val;
            end
            comp <= comp_next;
        end
    end

endmodule

// File: rtl/glw_write_gen.sv
// Module: glw_write_gen
// Builds the registered table write: one strobe per channel, a shared
// address and packed channel data. Channel c of the strobe vector is
// written by counter value NCH-1-c, so the counter order (red, green,
// blue) runs opposite to the mask order (blue, green, red).
module glw_write_gen
    import glw_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned PWL_W  = 7,
    parameter int unsigned CH_W   = 10,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NCH    = 3,
    parameter int unsigned CNT_W  = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  acc_t                acc,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                mode_pwl,
    input  logic [NCH-1:0]      mask,
    input  logic [IDX_W-1:0]    idx,
    input  logic [CNT_W-1:0]    comp,
    output logic [NCH-1:0]      tbl_we,
    output logic [IDX_W-1:0]    tbl_addr,
    output logic [NCH*CH_W-1:0] tbl_data,
    output logic                tbl_pwl
);

    logic                any_acc;
    logic [NCH-1:0]      we_d;
    logic [NCH*CH_W-1:0] data_d;
    logic [IDX_W-1:0]    addr_d;

    // Purpose: one strobe and data lane for each channel
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        logic hit;
        always_comb begin
            hit = acc.col ||
                  ((acc.seq || acc.pwl) && (comp == CNT_W'(NCH - 1 - ch)));
            we_d[ch] = hit && mask[ch];
            data_d[ch*CH_W +: CH_W] = acc.col ? wdata[ch*CH_W +: CH_W]
                                              : wdata[CH_W-1:0];
        end
    end

    // Purpose: form the slot address for the active layout
    always_comb begin
        any_acc = acc.seq | acc.pwl | acc.col;
        if (acc.pwl) begin
            addr_d = {{(IDX_W-PWL_W){1'b0}}, idx[PWL_W-1:0]};
        end else begin
            addr_d = idx;
        end
    end

    // Purpose: strobes last one cycle after each accepted write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_we <= '0;
        end else begin
            tbl_we <= we_d;
        end
    end

    // Purpose: address, data and layout tag, captured on channel writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tbl_addr <= '0;
            tbl_data <= '0;
            tbl_pwl  <= 1'b0;
        end else if (any_acc) begin
            tbl_addr <= addr_d;
            tbl_data <= data_d;
            tbl_pwl  <= mode_pwl;
        end
    end

endmodule

// File: rtl/gamma_lut_wport.sv
// Module: gamma_lut_wport (top)
// Register write front end for a gamma lookup table with a 256-slot
// layout and a piecewise layout. It decodes bus writes, keeps the slot
// pointer and the channel counter, and drives the table write strobes.
// Assumes one-cycle write strobes and no read path.
module gamma_lut_wport
    import glw_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned PWL_W  = 7,
    parameter int unsigned CH_W   = 10,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NCH    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_wr,
    input  logic [SEL_W-1:0]    bus_sel,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [NCH-1:0]      tbl_we,
    output logic [IDX_W-1:0]    tbl_addr,
    output logic [NCH*CH_W-1:0] tbl_data,
    output logic                tbl_pwl,
    output logic [IDX_W-1:0]    cur_index,
    output logic [$clog2(NCH)-1:0] cur_comp,
    output logic                cur_mode_pwl
);

    localparam int unsigned CNT_W = $clog2(NCH);

    acc_t           acc;
    logic           mode_pwl;
    logic [NCH-1:0] mask;

    glw_decode u_decode (
        .bus_wr   (bus_wr),
        .bus_sel  (bus_sel),
        .mode_pwl (mode_pwl),
        .acc      (acc)
    );

    glw_index_ctrl #(
        .IDX_W (IDX_W), .PWL_W (PWL_W), .DATA_W (DATA_W),
        .NCH (NCH), .CNT_W (CNT_W)
    ) u_index (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .wdata    (bus_wdata),
        .mode_pwl (mode_pwl),
        .mask     (mask),
        .idx      (cur_index),
        .comp     (cur_comp)
    );

    glw_write_gen #(
        .IDX_W (IDX_W), .PWL_W (PWL_W), .CH_W (CH_W), .DATA_W (DATA_W),
        .NCH (NCH), .CNT_W (CNT_W)
    ) u_wgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .acc      (acc),
        .wdata    (bus_wdata),
        .mode_pwl (mode_pwl),
        .mask     (mask),
        .idx      (cur_index),
        .comp     (cur_comp),
        .tbl_we   (tbl_we),
        .tbl_addr (tbl_addr),
        .tbl_data (tbl_data),
        .tbl_pwl  (tbl_pwl)
    );

    assign cur_mode_pwl = mode_pwl;

endmodule

// File: rtl/glw_checker.sv
// Module: glw_checker
// Property checks for gamma_lut_wport, attached through bind.
// It only observes ports and never drives anything.
module glw_checker
    import glw_pkg::*;
#(
    parameter int unsigned IDX_W  = 8,
    parameter int unsigned PWL_W  = 7,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned NCH    = 3,
    parameter int unsigned CNT_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [SEL_W-1:0]  bus_sel,
    input logic [DATA_W-1:0] bus_wdata,
    input logic [NCH-1:0]    tbl_we,
    input logic [IDX_W-1:0]  cur_index,
    input logic [CNT_W-1:0]  cur_comp,
    input logic              cur_mode_pwl
);

    AST_COMP_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_comp < CNT_W'(NCH)); // R4

    AST_NO_SPURIOUS_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> (tbl_we == '0)); // R3

    AST_SEQ_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (bus_sel == SEL_SEQ || bus_sel == SEL_PWL)) |=> $onehot0(tbl_we)); // R3

    AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == SEL_INDEX)
        |=> (cur_index == $past(bus_wdata[IDX_W-1:0]) && cur_comp == '0)); // R8

    AST_COL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == SEL_COL30 && !cur_mode_pwl)
        |=> (cur_index == IDX_W'($past(cur_index) + IDX_W'(1)) && cur_comp == '0)); // R7

    AST_PWL_KEEP_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_sel == SEL_PWL && cur_mode_pwl)
        |=> (cur_index[IDX_W-1:PWL_W] == $past(cur_index[IDX_W-1:PWL_W]))); // R6

    AST_WRONG_MODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && (((bus_sel == SEL_SEQ || bus_sel == SEL_COL30) && cur_mode_pwl)
                    || (bus_sel == SEL_PWL && !cur_mode_pwl)))
        |=> ($stable(cur_index) && $stable(cur_comp) && tbl_we == '0)); // R9

endmodule

bind gamma_lut_wport glw_checker #(
    .IDX_W (IDX_W), .PWL_W (PWL_W), .DATA_W (DATA_W),
    .NCH (NCH), .CNT_W ($clog2(NCH))
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .bus_wr       (bus_wr),
    .bus_sel      (bus_sel),
    .bus_wdata    (bus_wdata),
    .tbl_we       (tbl_we),
    .cur_index    (cur_index),
    .cur_comp     (cur_comp),
    .cur_mode_pwl (cur_mode_pwl)
);

// File: tb/gamma_lut_wport_tb.sv
// Bench for gamma_lut_wport: a vector table walked by one loop, then
// directed reset checks.
module gamma_lut_wport_tb;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  req;
        logic [2:0]  sel;
        logic [31:0] wd;
        logic [2:0]  we;
        logic [7:0]  addr;
        logic [29:0] data;
        logic [7:0]  idx;
        logic [1:0]  comp;
        logic        mode;
    } vec_t;

    // Fields: req, sel, wdata, exp strobes, exp addr, exp data {R,G,B}, exp ptr, exp counter, exp layout
    localparam int NV = 34;
    localparam vec_t VEC [NV] = '{
        '{4'd8, 3'd1, 32'h0000_0005, 3'b000, 8'h00, 30'h0, 8'h05, 2'd0, 1'b0}, // R8 pointer load
        '{4'd3, 3'd3, 32'hABC0_0011, 3'b100, 8'h05, {10'h011, 10'h0, 10'h0}, 8'h05, 2'd1, 1'b0}, // R3 red, upper bits ignored
        '{4'd3, 3'd3, 32'h0000_0022, 3'b010, 8'h05, {10'h0, 10'h022, 10'h0}, 8'h05, 2'd2, 1'b0}, // R3 green
        '{4'd4, 3'd3, 32'h0000_0033, 3'b001, 8'h05, {10'h0, 10'h0, 10'h033}, 8'h06, 2'd0, 1'b0}, // R4 blue and step
        '{4'd5, 3'd2, 32'h0000_0005, 3'b000, 8'h00, 30'h0, 8'h06, 2'd0, 1'b0}, // R5 mask red+blue
        '{4'd5, 3'd3, 32'h0000_0044, 3'b100, 8'h06, {10'h044, 10'h0, 10'h0}, 8'h06, 2'd1, 1'b0}, // R5
        '{4'd5, 3'd3, 32'h0000_0055, 3'b000, 8'h00, 30'h0, 8'h06, 2'd2, 1'b0}, // R5 green masked
        '{4'd5, 3'd3, 32'h0000_0066, 3'b001, 8'h06, {10'h0, 10'h0, 10'h066}, 8'h07, 2'd0, 1'b0}, // R5
        '{4'd5, 3'd2, 32'h0000_0007, 3'b000, 8'h00, 30'h0, 8'h07, 2'd0, 1'b0}, // R5 mask all
        '{4'd7, 3'd5, 32'h3FF5_56AA, 3'b111, 8'h07, {10'h3FF, 10'h155, 10'h2AA}, 8'h08, 2'd0, 1'b0}, // R7 packed
        '{4'd3, 3'd3, 32'h0000_0001, 3'b100, 8'h08, {10'h001, 10'h0, 10'h0}, 8'h08, 2'd1, 1'b0}, // R3
        '{4'd7, 3'd5, 32'h0010_0803, 3'b111, 8'h08, {10'h001, 10'h002, 10'h003}, 8'h09, 2'd0, 1'b0}, // R7 clears counter
        '{4'd3, 3'd3, 32'h0000_0005, 3'b100, 8'h09, {10'h005, 10'h0, 10'h0}, 8'h09, 2'd1, 1'b0}, // R3
        '{4'd9, 3'd4, 32'h0000_0007, 3'b000, 8'h00, 30'h0, 8'h09, 2'd1, 1'b0}, // R9 piecewise in 256 layout
        '{4'd9, 3'd7, 32'h0000_0123, 3'b000, 8'h00, 30'h0, 8'h09, 2'd1, 1'b0}, // R9 unused code
        '{4'd8, 3'd1, 32'h1234_56FF, 3'b000, 8'h00, 30'h0, 8'hFF, 2'd0, 1'b0}, // R8
        '{4'd3, 3'd3, 32'h0000_000A, 3'b100, 8'hFF, {10'h00A, 10'h0, 10'h0}, 8'hFF, 2'd1, 1'b0}, // R3
        '{4'd3, 3'd3, 32'h0000_000B, 3'b010, 8'hFF, {10'h0, 10'h00B, 10'h0}, 8'hFF, 2'd2, 1'b0}, // R3
        '{4'd4, 3'd3, 32'h0000_000C, 3'b001, 8'hFF, {10'h0, 10'h0, 10'h00C}, 8'h00, 2'd0, 1'b0}, // R4 wrap 255->0
        '{4'd2, 3'd0, 32'h0000_0001, 3'b000, 8'h00, 30'h0, 8'h00, 2'd0, 1'b1}, // R2 piecewise layout
        '{4'd9, 3'd3, 32'h0000_0009, 3'b000, 8'h00, 30'h0, 8'h00, 2'd0, 1'b1}, // R9
        '{4'd9, 3'd5, 32'h3FF5_56AA, 3'b000, 8'h00, 30'h0, 8'h00, 2'd0, 1'b1}, // R9
        '{4'd8, 3'd1, 32'h0000_00FF, 3'b000, 8'h00, 30'h0, 8'hFF, 2'd0, 1'b1}, // R8
        '{4'd6, 3'd4, 32'h0000_0010, 3'b100, 8'h7F, {10'h010, 10'h0, 10'h0}, 8'hFF, 2'd1, 1'b1}, // R6 addr drops bit 7
        '{4'd6, 3'd4, 32'h0000_0020, 3'b010, 8'h7F, {10'h0, 10'h020, 10'h0}, 8'hFF, 2'd2, 1'b1}, // R6
        '{4'd6, 3'd4, 32'h0000_0030, 3'b001, 8'h7F, {10'h0, 10'h0, 10'h030}, 8'h80, 2'd0, 1'b1}, // R6 7-bit wrap keeps bit 7
        '{4'd6, 3'd4, 32'h0000_0040, 3'b100, 8'h00, {10'h040, 10'h0, 10'h0}, 8'h80, 2'd1, 1'b1}, // R6
        '{4'd8, 3'd1, 32'h0000_0012, 3'b000, 8'h00, 30'h0, 8'h12, 2'd0, 1'b1}, // R8 clears counter
        '{4'd6, 3'd4, 32'h0000_0001, 3'b100, 8'h12, {10'h001, 10'h0, 10'h0}, 8'h12, 2'd1, 1'b1}, // R6
        '{4'd9, 3'd3, 32'h0000_0002, 3'b000, 8'h00, 30'h0, 8'h12, 2'd1, 1'b1}, // R9 counter kept
        '{4'd5, 3'd2, 32'h0000_0000, 3'b000, 8'h00, 30'h0, 8'h12, 2'd1, 1'b1}, // R5 mask none
        '{4'd5, 3'd4, 32'h0000_0002, 3'b000, 8'h00, 30'h0, 8'h12, 2'd2, 1'b1}, // R5
        '{4'd5, 3'd4, 32'h0000_0003, 3'b000, 8'h00, 30'h0, 8'h13, 2'd0, 1'b1}, // R5 masked still steps
        '{4'd2, 3'd0, 32'hFFFF_FFFE, 3'b000, 8'h00, 30'h0, 8'h13, 2'd0, 1'b0}  // R2 bit 0 only
    };

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_wr;
    logic [2:0]  bus_sel;
    logic [31:0] bus_wdata;
    logic [2:0]  tbl_we;
    logic [7:0]  tbl_addr;
    logic [29:0] tbl_data;
    logic        tbl_pwl;
    logic [7:0]  cur_index;
    logic [1:0]  cur_comp;
    logic        cur_mode_pwl;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gamma_lut_wport u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .bus_wr       (bus_wr),
        .bus_sel      (bus_sel),
        .bus_wdata    (bus_wdata),
        .tbl_we       (tbl_we),
        .tbl_addr     (tbl_addr),
        .tbl_data     (tbl_data),
        .tbl_pwl      (tbl_pwl),
        .cur_index    (cur_index),
        .cur_comp     (cur_comp),
        .cur_mode_pwl (cur_mode_pwl)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive one write on a falling edge; return at the next falling edge,
    // when the registered result of the write is visible.
    task automatic bus_write(input logic [2:0] sel, input logic [31:0] wd);
        @(negedge clk);
        bus_wr    = 1'b1;
        bus_sel   = sel;
        bus_wdata = wd;
        @(negedge clk);
        bus_wr    = 1'b0;
        bus_sel   = 3'd0;
        bus_wdata = 32'd0;
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n     = 1'b0;
        bus_wr    = 1'b0;
        bus_sel   = 3'd0;
        bus_wdata = 32'd0;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", "ptr", cur_index, 0);
        check("R1", "counter", cur_comp, 0);
        check("R1", "layout", cur_mode_pwl, 0);
        check("R1", "strobes", tbl_we, 0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d vec%0d", VEC[i].req, i);
            bus_write(VEC[i].sel, VEC[i].wd);
            check(rq, "strobes", tbl_we, VEC[i].we);
            check(rq, "ptr", cur_index, VEC[i].idx);
            check(rq, "counter", cur_comp, VEC[i].comp);
            check(rq, "layout", cur_mode_pwl, VEC[i].mode);
            if (VEC[i].we != 3'b000) begin
                check(rq, "addr", tbl_addr, VEC[i].addr);
                check(rq, "table tag", tbl_pwl, VEC[i].mode);
                for (int c = 0; c < 3; c++) begin
                    if (VEC[i].we[c])
                        check(rq, $sformatf("data ch%0d", c),
                              tbl_data[c*10 +: 10], VEC[i].data[c*10 +: 10]);
                end
            end
            @(negedge clk);
            check(rq, "strobe drop", tbl_we, 0); // R3 one-cycle strobe
        end

        // R1 mid-run reset: pointer 0x13, mask none, piecewise cleared
        bus_write(3'd0, 32'h1);
        bus_write(3'd4, 32'h5);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", "ptr after reset", cur_index, 0);
        check("R1", "counter after reset", cur_comp, 0);
        check("R1", "layout after reset", cur_mode_pwl, 0);
        rst_n = 1'b1;
        bus_write(3'd3, 32'h2A5);
        check("R1", "mask restored", tbl_we, 3'b100);
        check("R3", "addr after reset", tbl_addr, 0);
        check("R3", "red data after reset", tbl_data[29:20], 10'h2A5);
        check("R3", "table tag 256", tbl_pwl, 0);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule